// File: doc/BRIEF.md
# Snoop Data-Source Resolver

On a shared bus with private caches, a read that misses in the requesting cache is broadcast to every other cache and to main memory. Each cache checks its snoop directory and raises a hit line when it holds the block. This block takes those hit lines and picks exactly one supplier for the block. If at least one cache hits, memory is told to stay off the data bus, and a ripple priority chain grants the lowest-numbered hitting cache the right to drive the data. If no cache hits, memory supplies the block.

The block also tells the requester where the data came from. A block that a cache supplied is filled as shared and unmodified. A block that memory supplied is filled as exclusive and unmodified. The decision is registered once, when the request is accepted. It is then held for a transfer window of a configurable number of cycles, during which further requests are not taken. The number of caches, the window length and the chain implementation are parameters. The chain can be a bitwise ripple or a two's-complement lookahead form, and both give the same grant.

Top module: `snoop_src_resolver`

## Requirements
- R1: A `snoop_req` sampled high at a clock edge while no window is open is accepted, and `xfer_active` is high from that edge onward.
- R2: During a window, `mem_inhibit` is high if and only if at least one `cache_hit` bit was high in the accepting cycle.
- R3: During a window, `cache_grant` has exactly the bit of the lowest-index hitting cache set. Index 0 has the highest priority. The grant is never multi-hot.
- R4: When no cache hit in the accepting cycle, `mem_drive` is high and `cache_grant` is zero for the window. Every window has exactly one source: one grant bit or `mem_drive`.
- R5: During a window, `src_is_cache` is 1 when a cache supplies the block (the requester fills it as shared) and 0 when memory supplies it (the requester fills it as exclusive).
- R6: A window lasts exactly XFER_CYCLES cycles, and all outputs stay constant within it.
- R7: A `snoop_req` sampled while a window is open is ignored. It changes no output and opens no further window.
- R8: Outside a window, and after reset, `cache_grant`, `mem_inhibit`, `mem_drive`, `src_is_cache` and `xfer_active` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snoop_req | input | 1 | Bus read broadcast present this cycle |
| cache_hit | input | N_CACHES | Per-cache snoop directory match, valid with `snoop_req` |
| xfer_active | output | 1 | Transfer window open |
| cache_grant | output | N_CACHES | One-hot permission for one cache to drive data |
| mem_inhibit | output | 1 | Some cache hit, so memory must not drive the bus |
| mem_drive | output | 1 | Memory supplies the block |
| src_is_cache | output | 1 | Data source indication fed back to the requester |

## Verification
Request acceptance and window hold can fall in the same cycle. A new `snoop_req` with a different hit pattern can arrive while a transfer window is still open. The bench provokes this by driving such a request in the middle of a window. It judges the outcome by comparing every cycle of the open window against the item queued for the original request, then requiring that no unexpected window appears afterwards. Multiple-hit patterns also exercise the chain and the memory inhibit together in one accepting cycle.

// File: rtl/snoop_res_pkg.sv
package snoop_res_pkg;
   typedef enum logic [0:0] {
      CHAIN_RIPPLE    = 1'b0,
      CHAIN_LOOKAHEAD = 1'b1
   } chain_style_e;
endpackage

// File: rtl/snoop_prio_chain.sv
module snoop_prio_chain
   import snoop_res_pkg::*;
#(
   parameter int           N_CACHES    = 4,
   parameter chain_style_e CHAIN_STYLE = CHAIN_RIPPLE
) (
   input  logic [N_CACHES-1:0] hit_vec,
   output logic [N_CACHES-1:0] grant_vec,
   output logic                any_hit
);
   initial assert (N_CACHES >= 1) else $error("snoop_prio_chain: N_CACHES must be >= 1");

   generate
      if (CHAIN_STYLE == CHAIN_RIPPLE) begin : g_ripple
         logic [N_CACHES:0] pass_in;
         assign pass_in[0] = 1'b1;
         for (genvar i = 0; i < N_CACHES; i++) begin : g_stage
            // a stage forwards permission only if it is not claiming it
            assign grant_vec[i]   = pass_in[i] & hit_vec[i];
            assign pass_in[i+1]   = pass_in[i] & ~hit_vec[i];
         end
         assign any_hit = ~pass_in[N_CACHES];
      end else begin : g_lookahead
         logic [N_CACHES-1:0] neg_hit;
         assign neg_hit   = ~hit_vec + {{(N_CACHES-1){1'b0}}, 1'b1};
         assign grant_vec = hit_vec & neg_hit;
         assign any_hit   = |hit_vec;
      end
   endgenerate

   always_comb begin
      assert ($onehot0(grant_vec)) else $error("assert_grant_onehot_R3 violated");
   end
endmodule

// File: rtl/snoop_xfer_timer.sv
module snoop_xfer_timer #(
   parameter int XFER_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   output logic accept,
   output logic active
);
   localparam int CW = (XFER_CYCLES > 1) ? $clog2(XFER_CYCLES) : 1;
   localparam int LW = $clog2(XFER_CYCLES + 2);
   localparam logic [CW-1:0] LOAD_VAL = CW'(XFER_CYCLES - 1);

   initial assert (XFER_CYCLES >= 1) else $error("snoop_xfer_timer: XFER_CYCLES must be >= 1");

   logic [CW-1:0] remain;

   assign accept = start_req & ~active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         remain <= '0;
      end else if (accept) begin
         active <= 1'b1;
         remain <= LOAD_VAL;
      end else if (active) begin
         if (remain == '0) active <= 1'b0;
         else              remain <= remain - 1'b1;
      end
   end

   // independent window-length tally for checking
   logic [LW-1:0] run_len;
   always_ff @(posedge clk) begin
      if (!rst_n)      run_len <= '0;
      else if (accept) run_len <= LW'(1);
      else if (active) run_len <= run_len + 1'b1;
   end

   assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (run_len <= LW'(XFER_CYCLES)));
   assert_window_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> ($past(run_len) == LW'(XFER_CYCLES)));
   assert_busy_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && start_req) |-> !accept);
endmodule

// File: rtl/snoop_src_resolver.sv
module snoop_src_resolver
   import snoop_res_pkg::*;
#(
   parameter int           N_CACHES    = 4,
   parameter int           XFER_CYCLES = 2,
   parameter chain_style_e CHAIN_STYLE = CHAIN_RIPPLE
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                snoop_req,
   input  logic [N_CACHES-1:0] cache_hit,
   output logic                xfer_active,
   output logic [N_CACHES-1:0] cache_grant,
   output logic                mem_inhibit,
   output logic                mem_drive,
   output logic                src_is_cache
);
   logic [N_CACHES-1:0] grant_c;
   logic                any_hit_c;
   logic                accept;
   logic                active;
   logic [N_CACHES-1:0] grant_q;
   logic                hit_q;

   snoop_prio_chain #(
      .N_CACHES    (N_CACHES),
      .CHAIN_STYLE (CHAIN_STYLE)
   ) u_chain (
      .hit_vec   (cache_hit),
      .grant_vec (grant_c),
      .any_hit   (any_hit_c)
   );

   snoop_xfer_timer #(
      .XFER_CYCLES (XFER_CYCLES)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (snoop_req),
      .accept    (accept),
      .active    (active)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_q <= '0;
         hit_q   <= 1'b0;
      end else if (accept) begin
         grant_q <= grant_c;
         hit_q   <= any_hit_c;
      end
   end

   assign xfer_active  = active;
   assign cache_grant  = grant_q & {N_CACHES{active}};
   assign mem_inhibit  = hit_q & active;
   assign src_is_cache = hit_q & active;
   assign mem_drive    = ~hit_q & active;

   assert_single_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_active |-> ($countones({cache_grant, mem_drive}) == 1));
   assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_active && $past(xfer_active)) |-> ($stable(cache_grant) && $stable(mem_drive)));
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_active |-> (cache_grant == '0 && !mem_drive && !mem_inhibit));
   assert_inhibit_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_inhibit |-> (cache_grant != '0));
endmodule

// File: tb/snoop_src_resolver_tb_top.sv
module snoop_src_resolver_tb_top;
   localparam int NC = 4;
   localparam int XT = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          snoop_req = 1'b0;
   logic [NC-1:0] cache_hit = '0;
   logic          xfer_active;
   logic [NC-1:0] cache_grant;
   logic          mem_inhibit, mem_drive, src_is_cache;

   always #4 clk = ~clk;

   snoop_src_resolver #(.N_CACHES(NC), .XFER_CYCLES(XT)) dut_i (
      .clk(clk), .rst_n(rst_n), .snoop_req(snoop_req), .cache_hit(cache_hit),
      .xfer_active(xfer_active), .cache_grant(cache_grant),
      .mem_inhibit(mem_inhibit), .mem_drive(mem_drive), .src_is_cache(src_is_cache)
   );

   typedef struct { logic [NC-1:0] grant; logic from_cache; } exp_t;
   exp_t exp_q[$];
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   function automatic exp_t model(logic [NC-1:0] h);
      exp_t e;
      e.grant = '0;
      e.from_cache = 1'b0;
      for (int i = 0; i < NC; i++) begin
         if (h[i] && !e.from_cache) begin
            e.grant[i] = 1'b1;
            e.from_cache = 1'b1;
         end
      end
      return e;
   endfunction

   // monitor: compares every window cycle against the queued item
   bit   prev_act = 1'b0;
   int   win_len = 0;
   exp_t cur;
   always @(negedge clk) begin
      if (rst_n) begin
         if (xfer_active && !prev_act) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
               n_bad++;
               $display("FAIL R7: window opened with nothing expected (act=1 exp=0)");
               cur = model('0);
            end else cur = exp_q.pop_front();
            win_len = 0;
         end
         if (xfer_active) begin
            win_len++;
            n_cmp++;
            if (cache_grant !== cur.grant || mem_inhibit !== cur.from_cache ||
                src_is_cache !== cur.from_cache || mem_drive !== !cur.from_cache) begin
               n_bad++;
               $display("FAIL R2/R3/R4/R5: grant=%b inh=%b drv=%b src=%b exp grant=%b src=%b",
                        cache_grant, mem_inhibit, mem_drive, src_is_cache, cur.grant, cur.from_cache);
            end
         end else begin
            if (prev_act) begin
               n_cmp++;
               if (win_len != XT) begin
                  n_bad++;
                  $display("FAIL R6: window length %0d exp %0d", win_len, XT);
               end
            end
            n_cmp++;
            if (cache_grant !== '0 || mem_inhibit || mem_drive || src_is_cache) begin
               n_bad++;
               $display("FAIL R8: idle outputs grant=%b inh=%b drv=%b src=%b exp all 0",
                        cache_grant, mem_inhibit, mem_drive, src_is_cache);
            end
         end
         prev_act = xfer_active;
      end
   end

   task automatic issue(input logic [NC-1:0] h, input bit poke_mid);
      @(negedge clk);
      snoop_req = 1'b1;
      cache_hit = h;
      exp_q.push_back(model(h));
      @(negedge clk);
      snoop_req = 1'b0;
      cache_hit = '0;
      n_cmp++;
      if (xfer_active !== 1'b1) begin
         n_bad++;
         $display("FAIL R1: xfer_active=%b exp 1 after accepted request", xfer_active);
      end
      if (poke_mid) begin
         // R7: request during an open window with a different pattern
         snoop_req = 1'b1;
         cache_hit = ~h;
         @(negedge clk);
         snoop_req = 1'b0;
         cache_hit = '0;
      end
      repeat (XT + 1) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      n_cmp++;
      if (xfer_active || cache_grant !== '0 || mem_inhibit || mem_drive || src_is_cache) begin
         n_bad++;
         $display("FAIL R8: reset outputs act=%b grant=%b exp all 0", xfer_active, cache_grant);
      end
      rst_n = 1'b1;
      issue(4'b0000, 1'b0);          // R4 memory supplies
      issue(4'b0001, 1'b0);          // R3 single hits
      issue(4'b0010, 1'b0);
      issue(4'b0100, 1'b0);
      issue(4'b1000, 1'b0);
      issue(4'b1010, 1'b0);          // R3 priority among several
      issue(4'b1111, 1'b0);
      issue(4'b1100, 1'b0);
      issue(4'b0110, 1'b1);          // R7 request inside window
      issue(4'b0000, 1'b1);
      issue(4'b1000, 1'b1);
      repeat (4) @(negedge clk);
      n_cmp++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R1: %0d requests never produced a window, exp 0", exp_q.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run hung, exp completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule